// File: doc/BRIEF.md
# Integer Execute ALU With Optional Units

This block is the combinational execute stage of a 32-bit soft RISC core. It takes the full instruction word together with the two source operand values read from the register file. It returns the value to write back, which register field names the destination, and three control flags: write enable, illegal instruction and halt. The pipeline uses those flags to commit, trap or stop.

The operation code sits in instruction bits 31:26. Bit 31 also selects the form: 1 means register-register, 0 means register-immediate. The block covers these operations:
- addition and subtraction
- the five bitwise functions
- AND and OR against an immediate placed in the upper half
- six compare-and-set conditions
- multiplication
- byte and halfword sign extension
- three kinds of shift

Three build-time presence options remove the multiplier, the barrel shifter or the sign extender. The operations those units carry then become illegal. The one exception is a right shift by exactly one position, which stays legal through a single-step path.

Loads, stores, branches, control-register access and division are decoded elsewhere. This block reports them as no-write, not illegal and not halting.

Top module: `ialu_exec`

## Requirements
- R1: `dst_sel` equals instruction bit 31. `dst_reg` is bits 15:11 when bit 31 is 1 and bits 20:16 when it is 0.
- R2: Code 13 adds `src_a` and the sign-extended immediate bits 15:0. Code 45 adds `src_a` and `src_b`. Code 50 returns `src_a - src_b`. All results are modulo 2^32.
- R3: AND (8/40), OR (14/46), XOR (6/38), NOR (1/33) and XNOR (9/41) use `src_b` in register form. In immediate form they use the zero-extended immediate, and XNOR then returns the inverse of the XOR.
- R4: Code 24 returns `src_a AND (imm<<16)` and code 30 returns `src_a OR (imm<<16)`. The low 16 bits of the shifted immediate are zero.
- R5: The compare codes write 1 when the condition holds and 0 otherwise:
  - 25/57: equal
  - 31/63: not equal
  - 26/58: signed greater
  - 27/59: signed greater-or-equal
  - 29/61: unsigned greater
  - 28/60: unsigned greater-or-equal
  
  The immediate is sign-extended for the signed and equality forms and zero-extended for the unsigned forms.
- R6: Code 15/47 shifts left with zero fill, 5/37 shifts right arithmetically and 0/32 shifts right logically. The amount is bits 4:0 of the instruction in immediate form and bits 4:0 of `src_b` in register form.
- R7: Code 2/34 returns the low 32 bits of the product of `src_a` and the sign-extended immediate or `src_b`.
- R8: Code 44 sign-extends byte 7:0 of `src_a` and code 55 sign-extends halfword 15:0 of `src_a`.
- R9: Without the shifter, left shifts are illegal, and right shifts are illegal unless the amount is exactly 1.
- R10: Without the multiplier, multiply is illegal. Without the sign extender, codes 44 and 55 are illegal.
- R11: Code 40 with bits 25:11 all zero raises `halt` with `wr_en` and `illegal` low.
- R12: Codes 39, 42 and 53 are always illegal. Whenever `illegal` is high, `wr_en` is low.
- R13: Any code outside the lists above gives `wr_en`, `illegal` and `halt` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word: code, register fields, immediates |
| src_a | input | DATA_W | Operand read from the field at bits 25:21 |
| src_b | input | DATA_W | Operand read from the field at bits 20:16 |
| result | output | DATA_W | Value to write back, valid when `wr_en` is high |
| dst_sel | output | 1 | 1: destination field is bits 15:11; 0: bits 20:16 |
| dst_reg | output | 5 | Destination register index |
| wr_en | output | 1 | Result is to be written |
| illegal | output | 1 | Instruction traps as illegal |
| halt | output | 1 | Halt request from the reserved AND encoding |

## Verification
The bench builds two copies side by side and drives both with the same inputs. The first has all three units present and reaches every arithmetic, compare, shift, multiply and extension result. The second has none of them, which exercises every illegal-operation path and the single-step right shift that stays legal at an amount of one. Operand biasing toward zero, the sign boundary and all-ones reaches the signed and unsigned compare corners in both copies.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

   localparam int INSN_W   = 32;
   localparam int REGIDX_W = 5;
   localparam int IMM_W    = 16;
   localparam int CODE_W   = 6;

   typedef enum logic [4:0] {
      K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_XNOR,
      K_CEQ, K_CNE, K_CGT, K_CGE, K_CGTU, K_CGEU,
      K_SLL, K_SRA, K_SRL, K_MUL, K_SXB, K_SXH, K_BAD
   } kind_e;

   typedef enum logic [1:0] {
      IMM_SEXT, IMM_ZEXT, IMM_HIGH
   } imm_e;

   function automatic logic is_arith(input kind_e k);
      return k inside {K_ADD, K_SUB, K_CEQ, K_CNE, K_CGT, K_CGE, K_CGTU, K_CGEU, K_MUL};
   endfunction

   function automatic logic is_shift(input kind_e k);
      return k inside {K_SLL, K_SRA, K_SRL};
   endfunction

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
   import ialu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [INSN_W-1:0]   insn,
   output kind_e               kind,
   output logic                rr_form,
   output logic [DATA_W-1:0]   imm_val,
   output logic [REGIDX_W-1:0] dst_idx,
   output logic                halt_hit
);

   logic [CODE_W-1:0] code;
   imm_e              mode;
   logic [DATA_W-1:0] imm_z;
   logic [DATA_W-1:0] imm_s;

   assign code    = insn[INSN_W-1 -: CODE_W];
   assign rr_form = insn[INSN_W-1];

   always_comb begin
      kind = K_NONE;
      case (code)
         6'd0,  6'd32: kind = K_SRL;
         6'd1,  6'd33: kind = K_NOR;
         6'd2,  6'd34: kind = K_MUL;
         6'd5,  6'd37: kind = K_SRA;
         6'd6,  6'd38: kind = K_XOR;
         6'd8,  6'd40: kind = K_AND;
         6'd9,  6'd41: kind = K_XNOR;
         6'd13, 6'd45: kind = K_ADD;
         6'd14, 6'd46: kind = K_OR;
         6'd15, 6'd47: kind = K_SLL;
         6'd24:        kind = K_AND;
         6'd30:        kind = K_OR;
         6'd25, 6'd57: kind = K_CEQ;
         6'd26, 6'd58: kind = K_CGT;
         6'd27, 6'd59: kind = K_CGE;
         6'd28, 6'd60: kind = K_CGEU;
         6'd29, 6'd61: kind = K_CGTU;
         6'd31, 6'd63: kind = K_CNE;
         6'd50:        kind = K_SUB;
         6'd44:        kind = K_SXB;
         6'd55:        kind = K_SXH;
         6'd39, 6'd42, 6'd53: kind = K_BAD;
         default:      kind = K_NONE;
      endcase
   end

   always_comb begin
      if (code == 6'd24 || code == 6'd30) begin
         mode = IMM_HIGH;
      end else if (kind inside {K_ADD, K_MUL, K_CEQ, K_CNE, K_CGT, K_CGE}) begin
         mode = IMM_SEXT;
      end else begin
         mode = IMM_ZEXT;
      end
   end

   assign imm_z = DATA_W'(insn[IMM_W-1:0]);
   assign imm_s = DATA_W'($signed(insn[IMM_W-1:0]));

   always_comb begin
      case (mode)
         IMM_SEXT: imm_val = imm_s;
         IMM_HIGH: imm_val = imm_z << IMM_W;
         default:  imm_val = imm_z;
      endcase
   end

   assign dst_idx  = rr_form ? insn[15:11] : insn[20:16];
   assign halt_hit = (code == 6'd40) && (insn[25:11] == '0);

endmodule

// File: rtl/ialu_arith.sv
module ialu_arith
   import ialu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit HAS_MUL = 1'b1
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] diff;
   logic [DATA_W-1:0] prod;
   logic              eq;
   logic              gt_s;
   logic              gt_u;
   logic              flag;

   assign sum  = op_a + op_b;
   assign diff = op_a - op_b;
   assign eq   = (op_a == op_b);
   assign gt_s = $signed(op_a) > $signed(op_b);
   assign gt_u = op_a > op_b;

   generate
      if (HAS_MUL) begin : g_mul
         assign prod = op_a * op_b;
      end else begin : g_no_mul
         assign prod = '0;
      end
   endgenerate

   always_comb begin
      case (kind)
         K_CEQ:   flag = eq;
         K_CNE:   flag = !eq;
         K_CGT:   flag = gt_s;
         K_CGE:   flag = gt_s | eq;
         K_CGTU:  flag = gt_u;
         K_CGEU:  flag = gt_u | eq;
         default: flag = 1'b0;
      endcase
   end

   always_comb begin
      case (kind)
         K_ADD:   res = sum;
         K_SUB:   res = diff;
         K_MUL:   res = prod;
         default: res = DATA_W'(flag);
      endcase
   end

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
   import ialu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] res
);

   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

   logic [DATA_W-1:0] ext_b;
   logic [DATA_W-1:0] ext_h;

   assign ext_b = DATA_W'($signed(op_a[BYTE_W-1:0]));
   assign ext_h = DATA_W'($signed(op_a[HALF_W-1:0]));

   always_comb begin
      case (kind)
         K_AND:   res = op_a & op_b;
         K_OR:    res = op_a | op_b;
         K_XOR:   res = op_a ^ op_b;
         K_NOR:   res = ~(op_a | op_b);
         K_XNOR:  res = ~(op_a ^ op_b);
         K_SXB:   res = ext_b;
         K_SXH:   res = ext_h;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/ialu_shift.sv
module ialu_shift
   import ialu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit HAS_SHIFT = 1'b1,
   localparam int SHW      = $clog2(DATA_W)
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [SHW-1:0]    amount,
   output logic [DATA_W-1:0] res
);

   generate
      if (HAS_SHIFT) begin : g_barrel
         always_comb begin
            case (kind)
               K_SLL:   res = op_a << amount;
               K_SRA:   res = DATA_W'($signed(op_a) >>> amount);
               K_SRL:   res = op_a >> amount;
               default: res = '0;
            endcase
         end
      end else begin : g_single
         // Only a one-position right step exists; other amounts trap upstream.
         always_comb begin
            case (kind)
               K_SRA:   res = {op_a[DATA_W-1], op_a[DATA_W-1:1]};
               K_SRL:   res = {1'b0, op_a[DATA_W-1:1]};
               default: res = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
   import ialu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit HAS_MUL   = 1'b1,
   parameter bit HAS_SHIFT = 1'b1,
   parameter bit HAS_SEXT  = 1'b1
) (
   input  logic [31:0]       insn,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] result,
   output logic              dst_sel,
   output logic [4:0]        dst_reg,
   output logic              wr_en,
   output logic              illegal,
   output logic              halt
);

   localparam int SHW = $clog2(DATA_W);

   generate
      if (DATA_W < INSN_W) begin : g_chk_w
         $error("ialu_exec: DATA_W must be at least 32");
      end
      if ((1 << SHW) != DATA_W) begin : g_chk_p2
         $error("ialu_exec: DATA_W must be a power of two");
      end
   endgenerate

   kind_e             kind;
   logic              rr_form;
   logic [DATA_W-1:0] imm_val;
   logic [DATA_W-1:0] op_b;
   logic [SHW-1:0]    amount;
   logic              halt_hit;
   logic [DATA_W-1:0] r_arith;
   logic [DATA_W-1:0] r_logic;
   logic [DATA_W-1:0] r_shift;
   logic              trap;

   ialu_decode #(.DATA_W(DATA_W)) u_dec (
      .insn     (insn),
      .kind     (kind),
      .rr_form  (rr_form),
      .imm_val  (imm_val),
      .dst_idx  (dst_reg),
      .halt_hit (halt_hit)
   );

   assign op_b   = rr_form ? src_b : imm_val;
   assign amount = rr_form ? src_b[SHW-1:0] : insn[SHW-1:0];

   ialu_arith #(.DATA_W(DATA_W), .HAS_MUL(HAS_MUL)) u_arith (
      .kind (kind),
      .op_a (src_a),
      .op_b (op_b),
      .res  (r_arith)
   );

   ialu_logic #(.DATA_W(DATA_W)) u_logic (
      .kind (kind),
      .op_a (src_a),
      .op_b (op_b),
      .res  (r_logic)
   );

   ialu_shift #(.DATA_W(DATA_W), .HAS_SHIFT(HAS_SHIFT)) u_shift (
      .kind   (kind),
      .op_a   (src_a),
      .amount (amount),
      .res    (r_shift)
   );

   always_comb begin
      trap = 1'b0;
      case (kind)
         K_BAD:        trap = 1'b1;
         K_MUL:        trap = !HAS_MUL;
         K_SXB, K_SXH: trap = !HAS_SEXT;
         K_SLL:        trap = !HAS_SHIFT;
         K_SRA, K_SRL: trap = !HAS_SHIFT && (amount != SHW'(1));
         default:      trap = 1'b0;
      endcase
   end

   always_comb begin
      if (is_arith(kind))      result = r_arith;
      else if (is_shift(kind)) result = r_shift;
      else                     result = r_logic;
   end

   assign dst_sel = rr_form;
   assign illegal = trap;
   assign halt    = halt_hit;
   assign wr_en   = (kind != K_NONE) && !trap && !halt_hit;

endmodule

// File: rtl/ialu_exec_chk.sv
module ialu_exec_chk #(
   parameter int DATA_W    = 32,
   parameter bit HAS_SHIFT = 1'b1
) (
   input logic [31:0]       insn,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              illegal,
   input logic              halt
);

   logic [5:0] code;
   assign code = insn[31:26];

   always_comb begin
      // R12
      if (illegal) begin
         trap_no_write_chk: assert (!wr_en);
      end
      // R11
      if (halt) begin
         halt_quiet_chk: assert (!wr_en && !illegal);
      end
      // R5
      if (wr_en && (code[4:0] inside {5'd25, 5'd26, 5'd27, 5'd28, 5'd29, 5'd31})) begin
         cmp_bool_chk: assert (result[DATA_W-1:1] == '0);
      end
      // R4
      if (wr_en && code == 6'd24) begin
         andhi_low_chk: assert (result[15:0] == 16'h0);
      end
      // R4
      if (wr_en && code == 6'd30) begin
         orhi_low_chk: assert (result[15:0] == src_a[15:0]);
      end
      // R9
      if (!HAS_SHIFT && (code == 6'd15 || code == 6'd47)) begin
         no_left_shift_chk: assert (illegal);
      end
      // R8
      if (wr_en && code == 6'd44) begin
         sext_byte_chk: assert (result[DATA_W-1:7] == '0 || result[DATA_W-1:7] == '1);
      end
   end

endmodule

bind ialu_exec ialu_exec_chk #(.DATA_W(DATA_W), .HAS_SHIFT(HAS_SHIFT)) u_chk (
   .insn    (insn),
   .src_a   (src_a),
   .result  (result),
   .wr_en   (wr_en),
   .illegal (illegal),
   .halt    (halt)
);

// File: tb/tb_ialu_exec.sv
module tb_ialu_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] sa = '0;
   logic [31:0] sb = '0;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   logic [31:0] f_res, m_res;
   logic        f_sel, m_sel, f_wr, m_wr, f_ill, m_ill, f_hlt, m_hlt;
   logic [4:0]  f_dr, m_dr;

   ialu_exec #(.DATA_W(32), .HAS_MUL(1), .HAS_SHIFT(1), .HAS_SEXT(1)) dut (
      .insn(insn), .src_a(sa), .src_b(sb), .result(f_res), .dst_sel(f_sel),
      .dst_reg(f_dr), .wr_en(f_wr), .illegal(f_ill), .halt(f_hlt));

   ialu_exec #(.DATA_W(32), .HAS_MUL(0), .HAS_SHIFT(0), .HAS_SEXT(0)) dut_min (
      .insn(insn), .src_a(sa), .src_b(sb), .result(m_res), .dst_sel(m_sel),
      .dst_reg(m_dr), .wr_en(m_wr), .illegal(m_ill), .halt(m_hlt));

   function automatic string tag(input logic [5:0] c);
      case (c)
         6'd13, 6'd45, 6'd50:                       return "R2";
         6'd8, 6'd40, 6'd14, 6'd46, 6'd6, 6'd38,
         6'd1, 6'd33, 6'd9, 6'd41:                  return "R3";
         6'd24, 6'd30:                              return "R4";
         6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd31,
         6'd57, 6'd58, 6'd59, 6'd60, 6'd61, 6'd63:  return "R5";
         6'd0, 6'd32, 6'd5, 6'd37, 6'd15, 6'd47:    return "R6";
         6'd2, 6'd34:                               return "R7";
         6'd44, 6'd55:                              return "R8";
         6'd39, 6'd42, 6'd53:                       return "R12";
         default:                                   return "R13";
      endcase
   endfunction

   task automatic model(input bit full, input logic [31:0] i, a, b,
                        output logic e_wr, e_ill, e_hlt, output logic [31:0] e_res);
      logic [5:0]  c  = i[31:26];
      logic        rr = i[31];
      logic [31:0] sx = {{16{i[15]}}, i[15:0]};
      logic [31:0] zx = {16'h0, i[15:0]};
      logic [4:0]  sh = rr ? b[4:0] : i[4:0];
      logic [31:0] bs = rr ? b : sx;
      logic [31:0] bz = rr ? b : zx;
      bit          known = 1'b1;
      e_ill = 1'b0; e_hlt = 1'b0; e_res = '0;
      case (c)
         6'd13, 6'd45: e_res = a + bs;
         6'd50:        e_res = a - b;
         6'd8, 6'd40:  e_res = a & bz;
         6'd14, 6'd46: e_res = a | bz;
         6'd6, 6'd38:  e_res = a ^ bz;
         6'd1, 6'd33:  e_res = ~(a | bz);
         6'd9, 6'd41:  e_res = ~(a ^ bz);
         6'd24:        e_res = a & {i[15:0], 16'h0};
         6'd30:        e_res = a | {i[15:0], 16'h0};
         6'd25, 6'd57: e_res = {31'd0, a == bs};
         6'd31, 6'd63: e_res = {31'd0, a != bs};
         6'd26, 6'd58: e_res = {31'd0, $signed(a) > $signed(bs)};
         6'd27, 6'd59: e_res = {31'd0, $signed(a) >= $signed(bs)};
         6'd29, 6'd61: e_res = {31'd0, a > bz};
         6'd28, 6'd60: e_res = {31'd0, a >= bz};
         6'd15, 6'd47: begin e_res = a << sh; e_ill = !full; end
         6'd5, 6'd37:  begin e_res = $signed(a) >>> sh; e_ill = !full && sh != 5'd1; end
         6'd0, 6'd32:  begin e_res = a >> sh; e_ill = !full && sh != 5'd1; end
         6'd2, 6'd34:  begin e_res = a * bs; e_ill = !full; end
         6'd44:        begin e_res = {{24{a[7]}}, a[7:0]}; e_ill = !full; end
         6'd55:        begin e_res = {{16{a[15]}}, a[15:0]}; e_ill = !full; end
         6'd39, 6'd42, 6'd53: e_ill = 1'b1;
         default:      known = 1'b0;
      endcase
      if (c == 6'd40 && i[25:11] == 15'd0) e_hlt = 1'b1;
      e_wr = known && !e_ill && !e_hlt;
   endtask

   task automatic check_one(input bit full, input logic wr, ill, hlt, sel,
                            input logic [4:0] dr, input logic [31:0] res);
      logic        e_wr, e_ill, e_hlt;
      logic [31:0] e_res;
      logic [4:0]  e_dr = insn[31] ? insn[15:11] : insn[20:16];
      string       t;
      model(full, insn, sa, sb, e_wr, e_ill, e_hlt, e_res);
      t = tag(insn[31:26]);
      if (e_hlt) t = "R11";
      else if (e_ill && !full && (insn[31:26] inside {6'd0, 6'd32, 6'd5, 6'd37, 6'd15, 6'd47})) t = "R9";
      else if (e_ill && !full && (insn[31:26] inside {6'd2, 6'd34, 6'd44, 6'd55})) t = "R10";
      n_vec++;
      if (sel !== insn[31] || dr !== e_dr) begin
         n_bad++;
         $display("FAIL R1 full=%0b insn=%h got sel=%b reg=%0d exp sel=%b reg=%0d",
                  full, insn, sel, dr, insn[31], e_dr);
      end else if (wr !== e_wr || ill !== e_ill || hlt !== e_hlt || (e_wr && res !== e_res)) begin
         n_bad++;
         $display("FAIL %s full=%0b insn=%h a=%h b=%h got wr=%b ill=%b halt=%b res=%h exp wr=%b ill=%b halt=%b res=%h",
                  t, full, insn, sa, sb, wr, ill, hlt, res, e_wr, e_ill, e_hlt, e_res);
      end
   endtask

   task automatic apply(input logic [31:0] i, a, b);
      @(posedge clk);
      #1;
      insn = i; sa = a; sb = b;
      @(negedge clk);
      check_one(1'b1, f_wr, f_ill, f_hlt, f_sel, f_dr, f_res);
      check_one(1'b0, m_wr, m_ill, m_hlt, m_sel, m_dr, m_res);
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom % 6)
         0: return 32'h0;
         1: return 32'h8000_0000;
         2: return 32'h7fff_ffff;
         3: return 32'hffff_ffff;
         4: return 32'h1;
         default: return $urandom;
      endcase
   endfunction

   localparam logic [5:0] CODES [40] = '{
      6'd0, 6'd1, 6'd2, 6'd5, 6'd6, 6'd8, 6'd9, 6'd13, 6'd14, 6'd15,
      6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30, 6'd31, 6'd32, 6'd33,
      6'd34, 6'd37, 6'd38, 6'd40, 6'd41, 6'd44, 6'd45, 6'd46, 6'd47, 6'd50,
      6'd55, 6'd57, 6'd58, 6'd59, 6'd60, 6'd61, 6'd63, 6'd39, 6'd42, 6'd53};

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset state, all-zero word: R6 shift by zero; trap on the minimal build
      apply(32'h0, 32'h0, 32'h0);
      // R11 halt encoding and a near miss
      apply({6'd40, 26'h0}, 32'h1234, 32'h5678);
      apply({6'd40, 15'h0, 11'h001}, 32'h1234, 32'h5678);
      apply({6'd40, 15'h0001, 11'h0}, 32'hf0f0, 32'hff00);
      // R2 negative immediate
      apply({6'd13, 5'd3, 5'd4, 16'hffff}, 32'd5, 32'd0);
      // R9 single-step right shifts legal at amount 1, trap at 2
      apply({6'd0, 5'd1, 5'd2, 16'h0001}, 32'h8000_0003, 32'h0);
      apply({6'd5, 5'd1, 5'd2, 16'h0002}, 32'h8000_0003, 32'h0);
      apply({6'd37, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h8000_0003, 32'h0000_0021);
      apply({6'd32, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h8000_0003, 32'h0000_0022);
      // R5 signed vs unsigned boundaries
      apply({6'd58, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h7fff_ffff, 32'h8000_0000);
      apply({6'd61, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h7fff_ffff, 32'h8000_0000);
      apply({6'd28, 5'd1, 5'd2, 16'hffff}, 32'h0000_ffff, 32'h0);
      apply({6'd27, 5'd1, 5'd2, 16'hffff}, 32'hffff_ffff, 32'h0);
      // R4 high-half immediates, R3 immediate xnor
      apply({6'd24, 5'd1, 5'd2, 16'hf00f}, 32'hffff_ffff, 32'h0);
      apply({6'd30, 5'd1, 5'd2, 16'h8001}, 32'h0000_1234, 32'h0);
      apply({6'd9, 5'd1, 5'd2, 16'h00ff}, 32'h0000_0f0f, 32'h0);
      // R8 sign extension, R7 multiply, R12 reserved, R13 outside codes
      apply({6'd44, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h1234_5680, 32'h0);
      apply({6'd55, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h1234_7fff, 32'h0);
      apply({6'd2, 5'd1, 5'd2, 16'hfffe}, 32'd7, 32'h0);
      apply({6'd53, 26'h155}, 32'h1, 32'h1);
      apply({6'd4, 26'h0}, 32'h1, 32'h1);
      apply({6'd35, 26'h0}, 32'h1, 32'h0);
      for (int n = 0; n < 3000; n++) begin
         logic [5:0]  c;
         logic [25:0] rest;
         logic [31:0] a, b;
         c = ($urandom % 100 < 85) ? CODES[$urandom % 40] : 6'($urandom);
         rest = 26'($urandom);
         a = pick_val();
         b = pick_val();
         if ($urandom % 8 == 0) begin
            rest[4:0] = 5'd1;
            b[4:0] = 5'd1;
         end
         if ($urandom % 16 == 0) rest[25:11] = 15'd0;
         apply({c, rest}, a, b);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R13 watchdog: got still running, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule